// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block sits behind a serial slave front end and turns the bit stream into memory operations. The front end hands it a synchronized active-low select, a one-cycle strobe for each serial-clock rising edge together with the sampled input bit, and a strobe for each falling edge. From these the sequencer assembles bytes, decodes a one-byte opcode, and runs one of six commands. The commands are write-enable latch set and clear, array read, page write, status read and status write. It also owns the byte array and the busy window of an internal write.

Reads take a 16-bit address, most significant bit first. They stream bytes from that address onward and wrap from the top of the array back to zero. Writes collect a page of up to 32 bytes in a staging buffer. The buffer is committed only if select rises exactly on a byte boundary and the protection permit is high at that moment. After a commit the block stays busy for a parameterised number of system clocks while the staged bytes are copied into the array. The upper status bits come from an external protection block. A status write hands its byte back to that block through a one-cycle strobe.

Top module: `eeprom_cmd_seq`

## Requirements
- R1: After reset, busy and sdo_en are low, the write-enable latch is clear, and every array byte reads 0xFF.
- R2: Opcode 0x06 sets the write-enable latch and 0x04 clears it, both on the eighth opcode bit. If select rises before that bit arrives, the latch is unchanged.
- R3: Opcode 0x03 is followed by a 16-bit address, MSB first, taken modulo the array depth. Data leaves on sdo MSB first, starting at the falling-edge strobe after the last address bit. Each further 8 bits return the next address, and the byte after the highest address is address 0.
- R4: Opcode 0x02 is followed by a 16-bit address and data bytes. The write is committed only when select rises with at least one complete data byte received and no further rising-edge strobe after it. Otherwise nothing is written.
- R5: Within one page write only the low 5 address bits advance per byte. Data past 32 bytes wraps inside the same 32-byte page and replaces earlier bytes. Bytes outside the page are untouched.
- R6: A commit holds busy high for WR_CYCLES clocks. While busy, status reads show bit 0 = 1, and every opcode other than 0x05 is ignored.
- R7: A write or status write is committed only while the write-enable latch is set, and a commit clears the latch.
- R8: If wr_permit is low on the cycle select rises, the write or status write is dropped: busy stays low and the array is unchanged.
- R9: Opcode 0x01 takes exactly one data byte. A commit pulses stat_wr for one cycle with that byte on stat_wdata. Any extra rising-edge strobe before select rises drops it.
- R10: Opcode 0x05 returns {stat_hi[5:0], write-enable latch, busy}, MSB first, and repeats that byte for as long as clocks continue.
- R11: An unrecognised opcode leaves sdo_en low and changes no state until select rises.
- R12: Raising select ends a read or status read; sdo_en is low two cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Synchronized chip select, active low |
| sck_rise | input | 1 | One-cycle strobe: serial clock rising edge |
| sck_fall | input | 1 | One-cycle strobe: serial clock falling edge |
| sdi | input | 1 | Serial input bit, valid with sck_rise |
| sdo | output | 1 | Serial output bit |
| sdo_en | output | 1 | Output driver enable |
| wr_permit | input | 1 | Protection block grants the pending write |
| stat_hi | input | 6 | Upper status bits from the protection block |
| stat_wr | output | 1 | One-cycle strobe: committed status write |
| stat_wdata | output | 8 | Status byte for the protection block |
| busy | output | 1 | Internal write in progress |

## Verification
The bench targets the select-edge decisions. These are an opcode cut one bit short, a data byte followed by a stray bit, a write with no data byte, and a permit that drops just as select rises. A design that checks the position loosely would commit a torn write or set the latch early. A 34-byte page started two bytes below a page boundary exposes a design that carries into the upper address bits: it would spill into the next page rather than overwrite the first two bytes. A read from the top address catches a missing wrap to zero. Commands issued during busy, and a repeated status byte, catch a design that lets a second command through while busy or serves status only once.

// File: rtl/eeprom_seq_pkg.sv
`timescale 1ns/1ps
package eeprom_seq_pkg;
   localparam logic [7:0] OP_WRSR  = 8'h01;
   localparam logic [7:0] OP_WRITE = 8'h02;
   localparam logic [7:0] OP_READ  = 8'h03;
   localparam logic [7:0] OP_WRDI  = 8'h04;
   localparam logic [7:0] OP_RDSR  = 8'h05;
   localparam logic [7:0] OP_WREN  = 8'h06;

   typedef enum logic [2:0] {
      ST_OPC,
      ST_ADR,
      ST_RDAT,
      ST_WDAT,
      ST_RSTAT,
      ST_WSTAT,
      ST_WSFULL,
      ST_SKIP
   } seq_state_e;
endpackage

// File: rtl/eeprom_bit_shifter.sv
`timescale 1ns/1ps
module eeprom_bit_shifter (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sck_rise,
   input  logic       sdi,
   output logic       byte_done,
   output logic [7:0] byte_val,
   output logic [2:0] bit_pos
);
   logic [6:0] sh_q;
   logic [2:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (cs_n) begin
         cnt_q <= '0;
      end else if (sck_rise) begin
         sh_q  <= {sh_q[5:0], sdi};
         cnt_q <= cnt_q + 3'd1;
      end
   end

   assign byte_done = sck_rise & ~cs_n & (cnt_q == 3'd7);
   assign byte_val  = {sh_q, sdi};
   assign bit_pos   = cnt_q;

   // R4: the position restarts at every select edge, so a new frame is byte aligned
   assert_pos_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (bit_pos == 3'd0));
endmodule

// File: rtl/eeprom_page_buf.sv
`timescale 1ns/1ps
module eeprom_page_buf #(
   parameter int PAGE_AW = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       we,
   input  logic [PAGE_AW-1:0]         idx,
   input  logic [7:0]                 wdata,
   output logic [(1<<PAGE_AW)*8-1:0]  data_flat,
   output logic [(1<<PAGE_AW)-1:0]    valid
);
   localparam int PB = 1 << PAGE_AW;

   for (genvar g = 0; g < PB; g++) begin : g_slot
      logic [7:0] ent_q;
      logic       val_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_q <= '0;
            val_q <= 1'b0;
         end else if (clr) begin
            val_q <= 1'b0;
         end else if (we && (idx == PAGE_AW'(g))) begin
            ent_q <= wdata;
            val_q <= 1'b1;
         end
      end
      assign data_flat[g*8 +: 8] = ent_q;
      assign valid[g]            = val_q;
   end

   // R5: a single data byte marks at most one slot per cycle
   assert_one_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !clr) |=> ($countones(valid & ~$past(valid)) <= 1));
endmodule

// File: rtl/eeprom_store.sv
`timescale 1ns/1ps
module eeprom_store #(
   parameter int MEM_AW    = 8,
   parameter int PAGE_AW   = 5,
   parameter int WR_CYCLES = 1000
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic                       start_page,
   input  logic [MEM_AW-PAGE_AW-1:0]  base,
   input  logic [(1<<PAGE_AW)*8-1:0]  pg_data,
   input  logic [(1<<PAGE_AW)-1:0]    pg_valid,
   input  logic [MEM_AW-1:0]          rd_addr,
   output logic [7:0]                 rd_data,
   output logic                       busy
);
   localparam int PB    = 1 << PAGE_AW;
   localparam int DEPTH = 1 << MEM_AW;
   localparam int CNT_W = $clog2(WR_CYCLES + 1);

   logic [7:0]                mem_q [DEPTH];
   logic                      busy_q;
   logic                      page_q;
   logic [MEM_AW-PAGE_AW-1:0] base_q;
   logic [CNT_W-1:0]          cnt_q;
   logic [PAGE_AW-1:0]        slot;
   logic                      wr_hit;

   assign slot   = cnt_q[PAGE_AW-1:0];
   assign wr_hit = page_q && (cnt_q < CNT_W'(PB)) && pg_valid[slot];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
         busy_q <= 1'b0;
         page_q <= 1'b0;
         base_q <= '0;
         cnt_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         page_q <= start_page;
         base_q <= base;
         cnt_q  <= '0;
      end else if (busy_q) begin
         if (wr_hit) mem_q[{base_q, slot}] <= pg_data[slot*8 +: 8];
         cnt_q <= cnt_q + CNT_W'(1);
         if (cnt_q == CNT_W'(WR_CYCLES - 1)) busy_q <= 1'b0;
      end
   end

   assign rd_data = mem_q[rd_addr];
   assign busy    = busy_q;

   // R6: the sequencer never launches a commit on top of a running one
   assert_start_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy_q);
   // R6: the busy window never outlasts its programmed length
   assert_busy_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q < CNT_W'(WR_CYCLES)));
endmodule

// File: rtl/eeprom_cmd_seq.sv
`timescale 1ns/1ps
module eeprom_cmd_seq
   import eeprom_seq_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int MEM_AW    = 8,
   parameter int PAGE_AW   = 5,
   parameter int WR_CYCLES = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sck_rise,
   input  logic       sck_fall,
   input  logic       sdi,
   output logic       sdo,
   output logic       sdo_en,
   input  logic       wr_permit,
   input  logic [5:0] stat_hi,
   output logic       stat_wr,
   output logic [7:0] stat_wdata,
   output logic       busy
);
   localparam int PB         = 1 << PAGE_AW;
   localparam int SEG_W      = MEM_AW - PAGE_AW;
   localparam int ADDR_BYTES = ADDR_W / 8;
   localparam int ACNT_W     = $clog2(ADDR_BYTES + 1);

   if ((ADDR_W % 8) != 0 || ADDR_W < 16) begin : g_bad_addr
      $error("ADDR_W must be a whole number of bytes and at least 16");
   end
   if (MEM_AW <= PAGE_AW || MEM_AW > ADDR_W) begin : g_bad_mem
      $error("MEM_AW must exceed PAGE_AW and fit in ADDR_W");
   end
   if (WR_CYCLES < PB) begin : g_bad_time
      $error("WR_CYCLES must cover one cycle per page byte");
   end

   logic             byte_done;
   logic [7:0]       rx_byte;
   logic [2:0]       bit_pos;
   seq_state_e       st_q;
   logic             cs_q;
   logic             cs_rise;
   logic             is_read_q;
   logic [ACNT_W-1:0] acnt_q;
   logic [MEM_AW-1:0] addr_q;
   logic [MEM_AW-1:0] addr_nx;
   logic [MEM_AW-1:0] rd_addr_q;
   logic [SEG_W-1:0]  base_q;
   logic [PAGE_AW-1:0] pidx_q;
   logic             have_q;
   logic [2:0]       obit_q;
   logic             wen_q;
   logic             sdo_q;
   logic             sdo_en_q;
   logic [7:0]       ws_byte_q;
   logic             stat_wr_q;
   logic [7:0]       stat_wdata_q;
   logic [7:0]       stat_byte;
   logic [7:0]       rd_data;
   logic             store_busy;
   logic             pb_we;
   logic             pb_clr;
   logic [PB*8-1:0]  pb_data;
   logic [PB-1:0]    pb_valid;
   logic             page_commit;
   logic             stat_commit;
   logic             store_start;

   eeprom_bit_shifter i_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .sck_rise  (sck_rise),
      .sdi       (sdi),
      .byte_done (byte_done),
      .byte_val  (rx_byte),
      .bit_pos   (bit_pos)
   );

   assign cs_rise   = cs_n & ~cs_q;
   assign addr_nx   = MEM_AW'({addr_q, rx_byte});
   assign stat_byte = {stat_hi, wen_q, store_busy};

   assign page_commit = cs_rise && (st_q == ST_WDAT) && (bit_pos == 3'd0) &&
                        have_q && wen_q && wr_permit;
   assign stat_commit = cs_rise && (st_q == ST_WSFULL) && (bit_pos == 3'd0) &&
                        wen_q && wr_permit;
   assign store_start = page_commit || stat_commit;

   assign pb_we  = !cs_n && (st_q == ST_WDAT) && byte_done;
   assign pb_clr = !cs_n && (st_q == ST_OPC) && byte_done && !store_busy &&
                   (rx_byte == OP_WRITE);

   eeprom_page_buf #(.PAGE_AW(PAGE_AW)) i_page (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (pb_clr),
      .we        (pb_we),
      .idx       (pidx_q),
      .wdata     (rx_byte),
      .data_flat (pb_data),
      .valid     (pb_valid)
   );

   eeprom_store #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW), .WR_CYCLES(WR_CYCLES)) i_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (store_start),
      .start_page (page_commit),
      .base       (base_q),
      .pg_data    (pb_data),
      .pg_valid   (pb_valid),
      .rd_addr    (rd_addr_q),
      .rd_data    (rd_data),
      .busy       (store_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_OPC;
         cs_q         <= 1'b1;
         is_read_q    <= 1'b0;
         acnt_q       <= '0;
         addr_q       <= '0;
         rd_addr_q    <= '0;
         base_q       <= '0;
         pidx_q       <= '0;
         have_q       <= 1'b0;
         obit_q       <= '0;
         wen_q        <= 1'b0;
         sdo_q        <= 1'b0;
         sdo_en_q     <= 1'b0;
         ws_byte_q    <= '0;
         stat_wr_q    <= 1'b0;
         stat_wdata_q <= '0;
      end else begin
         cs_q      <= cs_n;
         stat_wr_q <= 1'b0;
         if (store_start) wen_q <= 1'b0;
         if (stat_commit) begin
            stat_wr_q    <= 1'b1;
            stat_wdata_q <= ws_byte_q;
         end
         if (cs_n) begin
            st_q     <= ST_OPC;
            sdo_en_q <= 1'b0;
            acnt_q   <= '0;
         end else begin
            case (st_q)
               ST_OPC: if (byte_done) begin
                  obit_q <= '0;
                  if (store_busy) begin
                     st_q <= (rx_byte == OP_RDSR) ? ST_RSTAT : ST_SKIP;
                  end else begin
                     case (rx_byte)
                        OP_WREN:  begin wen_q <= 1'b1; st_q <= ST_SKIP; end
                        OP_WRDI:  begin wen_q <= 1'b0; st_q <= ST_SKIP; end
                        OP_READ:  begin is_read_q <= 1'b1; st_q <= ST_ADR; end
                        OP_WRITE: begin is_read_q <= 1'b0; st_q <= ST_ADR; end
                        OP_RDSR:  st_q <= ST_RSTAT;
                        OP_WRSR:  st_q <= ST_WSTAT;
                        default:  st_q <= ST_SKIP;
                     endcase
                  end
               end
               ST_ADR: if (byte_done) begin
                  addr_q <= addr_nx;
                  acnt_q <= acnt_q + ACNT_W'(1);
                  if (acnt_q == ACNT_W'(ADDR_BYTES - 1)) begin
                     if (is_read_q) begin
                        rd_addr_q <= addr_nx;
                        st_q      <= ST_RDAT;
                     end else begin
                        base_q <= addr_nx[MEM_AW-1:PAGE_AW];
                        pidx_q <= addr_nx[PAGE_AW-1:0];
                        have_q <= 1'b0;
                        st_q   <= ST_WDAT;
                     end
                  end
               end
               ST_WDAT: if (byte_done) begin
                  pidx_q <= pidx_q + PAGE_AW'(1);
                  have_q <= 1'b1;
               end
               ST_RDAT: if (sck_fall) begin
                  sdo_q    <= rd_data[3'd7 - obit_q];
                  sdo_en_q <= 1'b1;
                  obit_q   <= obit_q + 3'd1;
                  if (obit_q == 3'd7) rd_addr_q <= rd_addr_q + MEM_AW'(1);
               end
               ST_RSTAT: if (sck_fall) begin
                  sdo_q    <= stat_byte[3'd7 - obit_q];
                  sdo_en_q <= 1'b1;
                  obit_q   <= obit_q + 3'd1;
               end
               ST_WSTAT: if (byte_done) begin
                  ws_byte_q <= rx_byte;
                  st_q      <= ST_WSFULL;
               end
               ST_WSFULL: if (sck_rise) st_q <= ST_SKIP;
               default: ;
            endcase
         end
      end
   end

   assign sdo        = sdo_q;
   assign sdo_en     = sdo_en_q;
   assign stat_wr    = stat_wr_q;
   assign stat_wdata = stat_wdata_q;
   assign busy       = store_busy;

   // R6: no page byte is staged while the array is being programmed
   assert_no_fill_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      store_busy |-> !pb_we);
   // R7: every commit starts the busy window and drops the enable latch
   assert_commit_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
      store_start |=> (store_busy && !wen_q));
   // R9: a status strobe always coincides with an internal write window
   assert_stat_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr_q |-> (store_busy && $past(wen_q)));
   // R12: with select held high the output stays released
   assert_sdo_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && cs_q) |-> !sdo_en_q);
endmodule

// File: tb/test_eeprom_cmd_seq.sv
`timescale 1ns/1ps
module test_eeprom_cmd_seq;
   localparam int WRC = 300;
   localparam logic [5:0] SHI = 6'b101001;
   localparam logic [7:0] ST_IDLE = {SHI, 2'b00};
   localparam logic [7:0] ST_WEN  = {SHI, 2'b10};
   localparam logic [7:0] ST_BUSY = {SHI, 2'b01};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sck_rise = 1'b0;
   logic sck_fall = 1'b0;
   logic sdi = 1'b0;
   logic wr_permit = 1'b1;
   logic sdo, sdo_en, stat_wr, busy;
   logic [7:0] stat_wdata;

   int n_chk = 0;
   int n_fail = 0;
   int ws_cnt = 0;
   logic [7:0] ws_last = 8'h00;

   always #2 clk = ~clk;

   eeprom_cmd_seq #(.ADDR_W(16), .MEM_AW(8), .PAGE_AW(5), .WR_CYCLES(WRC)) i_eeprom_cmd_seq (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
      .sdi(sdi), .sdo(sdo), .sdo_en(sdo_en), .wr_permit(wr_permit), .stat_hi(SHI),
      .stat_wr(stat_wr), .stat_wdata(stat_wdata), .busy(busy)
   );

   always @(negedge clk) if (rst_n && stat_wr) begin
      ws_cnt  <= ws_cnt + 1;
      ws_last <= stat_wdata;
   end

   // {address, data, permit}: expected readback is data when permitted, else erased
   localparam logic [24:0] VEC [6] = '{
      {16'h0040, 8'h3C, 1'b1},
      {16'h0041, 8'h99, 1'b0},
      {16'h1234, 8'hC3, 1'b1},
      {16'h0080, 8'h01, 1'b1},
      {16'h00C7, 8'h7E, 1'b0},
      {16'h0055, 8'hA5, 1'b1}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_x(input logic b, output logic s);
      @(negedge clk);
      sdi = b;
      s = sdo;
      sck_rise = 1'b1;
      @(negedge clk);
      sck_rise = 1'b0;
      @(negedge clk);
      sck_fall = 1'b1;
      @(negedge clk);
      sck_fall = 1'b0;
   endtask

   task automatic byte_x(input logic [7:0] b, output logic [7:0] r);
      for (int i = 7; i >= 0; i--) bit_x(b[i], r[i]);
   endtask

   task automatic sel();
      @(negedge clk);
      cs_n = 1'b0;
   endtask

   task automatic desel();
      @(negedge clk);
      cs_n = 1'b1;
      tick(2);
   endtask

   task automatic cmd1(input logic [7:0] op);
      logic [7:0] r;
      sel(); byte_x(op, r); desel();
   endtask

   task automatic rd_status(output logic [7:0] s);
      logic [7:0] r;
      sel(); byte_x(8'h05, r); byte_x(8'h00, s); desel();
   endtask

   task automatic mem_write(input logic [15:0] a, input logic [7:0] d);
      logic [7:0] r;
      sel(); byte_x(8'h02, r); byte_x(a[15:8], r); byte_x(a[7:0], r); byte_x(d, r); desel();
   endtask

   task automatic mem_read(input logic [15:0] a, output logic [7:0] d, output logic en);
      logic [7:0] r;
      sel(); byte_x(8'h03, r); byte_x(a[15:8], r); byte_x(a[7:0], r); byte_x(8'h00, d);
      en = sdo_en;
      desel();
   endtask

   task automatic wait_ready();
      for (int i = 0; i < 2000; i++) begin
         if (!busy) break;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] s, d, d1, d2, r;
      logic en, b;
      tick(5);
      rst_n = 1'b1;
      tick(2);

      // R1 reset state
      check("R1 busy", busy, 0);
      check("R1 sdo_en", sdo_en, 0);
      rd_status(s);
      check("R1 status", s, ST_IDLE);
      mem_read(16'h0010, d, en);
      check("R1 erased", d, 8'hFF);

      // R2 latch set/clear, short opcode
      sel();
      for (int i = 7; i >= 1; i--) bit_x(OPW(i), b);
      desel();
      rd_status(s);
      check("R2 short opcode", s, ST_IDLE);
      cmd1(8'h06);
      rd_status(s);
      check("R2 enable", s, ST_WEN);
      cmd1(8'h04);
      rd_status(s);
      check("R2 disable", s, ST_IDLE);

      // R4 R8 table of single-byte writes
      for (int v = 0; v < 6; v++) begin
         wr_permit = VEC[v][0];
         cmd1(8'h06);
         mem_write(VEC[v][24:9], VEC[v][8:1]);
         check("R8 busy after select rise", busy, VEC[v][0]);
         wait_ready();
         wr_permit = 1'b1;
         mem_read(VEC[v][24:9], d, en);
         check("R4 R8 readback", d, VEC[v][0] ? VEC[v][8:1] : 8'hFF);
         if (v == 0) begin
            rd_status(s);
            check("R7 latch cleared by commit", s, ST_IDLE);
         end
      end

      // R7 write without latch
      cmd1(8'h04);
      mem_write(16'h0060, 8'h11);
      check("R7 no busy without latch", busy, 0);
      mem_read(16'h0060, d, en);
      check("R7 unchanged", d, 8'hFF);

      // R4 stray bit and empty write
      cmd1(8'h06);
      sel(); byte_x(8'h02, r); byte_x(8'h00, r); byte_x(8'h61, r); byte_x(8'h22, r); bit_x(1'b1, b); desel();
      check("R4 stray bit busy", busy, 0);
      mem_read(16'h0061, d, en);
      check("R4 stray bit unchanged", d, 8'hFF);
      sel(); byte_x(8'h02, r); byte_x(8'h00, r); byte_x(8'h62, r); desel();
      check("R4 empty write busy", busy, 0);
      cmd1(8'h04);

      // R5 page wrap
      cmd1(8'h06);
      sel(); byte_x(8'h02, r); byte_x(8'h00, r); byte_x(8'h1E, r);
      for (int k = 0; k < 34; k++) byte_x(8'h40 + 8'(k), r);
      desel();
      wait_ready();
      mem_read(16'h001E, d, en); check("R5 overwrite 1E", d, 8'h60);
      mem_read(16'h001F, d, en); check("R5 overwrite 1F", d, 8'h61);
      mem_read(16'h0000, d, en); check("R5 wrap 00", d, 8'h42);
      mem_read(16'h001D, d, en); check("R5 wrap 1D", d, 8'h5F);
      mem_read(16'h0020, d, en); check("R5 no spill", d, 8'hFF);

      // R6 busy behaviour
      cmd1(8'h06);
      mem_write(16'h0070, 8'h33);
      rd_status(s);
      check("R6 busy status", s, ST_BUSY);
      cmd1(8'h06);
      mem_read(16'h0070, d, en);
      check("R6 read ignored", en, 0);
      wait_ready();
      rd_status(s);
      check("R6 enable ignored", s, ST_IDLE);
      mem_read(16'h0070, d, en);
      check("R6 data landed", d, 8'h33);

      // R3 wrap at top, address modulo depth
      cmd1(8'h06);
      mem_write(16'h00FF, 8'h5A);
      wait_ready();
      sel(); byte_x(8'h03, r); byte_x(8'h01, r); byte_x(8'hFF, r);
      byte_x(8'h00, d); byte_x(8'h00, d1); byte_x(8'h00, d2); desel();
      check("R3 top byte", d, 8'h5A);
      check("R3 wrap to 0", d1, 8'h42);
      check("R3 next", d2, 8'h43);

      // R10 repeated status
      sel(); byte_x(8'h05, r); byte_x(8'h00, d); byte_x(8'h00, d1); desel();
      check("R10 first", d, ST_IDLE);
      check("R10 repeat", d1, ST_IDLE);

      // R9 status write
      cmd1(8'h06);
      sel(); byte_x(8'h01, r); byte_x(8'h0C, r); desel();
      check("R9 strobe count", ws_cnt, 1);
      check("R9 strobe data", ws_last, 8'h0C);
      check("R9 busy", busy, 1);
      wait_ready();
      cmd1(8'h06);
      sel(); byte_x(8'h01, r); byte_x(8'h08, r); bit_x(1'b0, b); desel();
      check("R9 stray bit", ws_cnt, 1);
      wr_permit = 1'b0;
      sel(); byte_x(8'h01, r); byte_x(8'h08, r); desel();
      check("R8 status permit", ws_cnt, 1);
      wr_permit = 1'b1;
      cmd1(8'h04);

      // R11 unknown opcode
      cmd1(8'h06);
      sel(); byte_x(8'hAB, r); byte_x(8'h04, r);
      check("R11 no output", sdo_en, 0);
      desel();
      rd_status(s);
      check("R11 latch kept", s, ST_WEN);
      cmd1(8'h04);

      // R12 select ends read
      sel(); byte_x(8'h03, r); byte_x(8'h00, r); byte_x(8'h1E, r); byte_x(8'h00, d);
      check("R12 driving", sdo_en, 1);
      check("R12 data", d, 8'h60);
      desel();
      check("R12 released", sdo_en, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   function automatic logic OPW(input int i);
      logic [7:0] w = 8'h06;
      return w[i];
   endfunction
endmodule